// File: doc/BRIEF.md
# Flash Erase/Program Command Sequencer

This block sits between a host register bus and a behavioural flash-array model. Software writes a 16-bit command word to a single control register. The low fifteen bits choose the operation and bit 15 is the start flag. When the start flag is written to 1 while the sequencer is idle, it decodes the operation and holds the start flag high for a fixed number of clock cycles. In the last of those cycles it pulses the matching strobe on the array port. Then it drops the start flag by itself. Software learns that the operation is complete by reading the register back until bit 15 is 0.

Erase operations follow a nesting rule. Erasing the secure segment also wipes the general segment. A bulk erase wipes all code, executive and protection-configuration storage, but it never touches the identification registers. The cycle counts are parameters and stand in for real erase and program times. The defaults give erases longer durations than writes. Command values that decode to nothing raise the start flag for one cycle only and set an error indication. Any write made while an operation is running is dropped, so the command cannot change mid-cycle.

Top module: `flash_cmd_seq`

## Requirements
- R1: A control write (`reg_wr`=1) with `reg_wdata[15]`=1 while idle sets the start flag. From the next cycle `busy`=1 and `reg_rdata` equals {1, written bits 14:0}.
- R2: The start flag stays high for exactly the cycle count of the operation class and then clears by itself, with `busy` always equal to `reg_rdata[15]`. The defaults are: bulk erase 40, segment erase 24, page erase 16, row program 10, word program 4, config-byte write 3.
- R3: Command 0x404F drives `erase_mask` = 7'h3F. The region bits are: 0 general segment, 1 general config, 2 secure segment, 3 secure config, 4 executive memory, 5 protection config. Bit 6 is the identification registers and must stay 0.
- R4: Command 0x404D drives `erase_mask` = 7'h03 (general segment and its config only).
- R5: Command 0x404C drives `erase_mask` = 7'h0F (secure segment and its config, plus general segment and its config).
- R6: Command 0x4042 pulses `page_erase` and leaves `erase_mask` at 0.
- R7: Command 0x4001 pulses `row_prog`, 0x4003 pulses `word_prog`, and 0x4000 pulses `cfg_prog`.
- R8: Each valid operation produces exactly one strobe cycle, and that cycle is the last cycle with `busy`=1. No strobe is asserted at any other time and at most one strobe kind is active at a time.
- R9: Launching any other command value holds `busy` for exactly one cycle, produces no strobe and sets `err`. The next accepted control write clears `err`.
- R10: Control writes while `busy`=1 are ignored: `reg_rdata[14:0]` is unchanged and the running operation keeps its original length and strobe.
- R11: A control write with bit 15 = 0 while idle stores bits 14:0 into `reg_rdata[14:0]` and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control write data: bit 15 start, bits 14:0 command |
| reg_rdata | output | 16 | Control readback: {start flag, stored command} |
| busy | output | 1 | High while an operation runs (equals start flag) |
| err | output | 1 | Last launch used an undecoded command |
| erase_mask | output | 7 | Region erase strobe, one bit per region |
| page_erase | output | 1 | Page erase strobe |
| row_prog | output | 1 | Row program strobe |
| word_prog | output | 1 | Word program strobe |
| cfg_prog | output | 1 | Config-byte write strobe |

## Verification
A corrupted stored operation class would show on the array port on the last busy cycle, as the wrong strobe or the wrong erase mask. The start-to-end window is at most the longest cycle count. A countdown that loads the wrong value or stalls would show as a `busy` window of the wrong length, and the bench measures every window exactly against the arithmetic count for its command. A start flag that accepted writes mid-operation would change the readback command within one cycle of the offending write.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_BULK  = 3'd1,
    OP_GSEG  = 3'd2,
    OP_SSEG  = 3'd3,
    OP_PAGE  = 3'd4,
    OP_ROW   = 3'd5,
    OP_WORD  = 3'd6,
    OP_CFG   = 3'd7
  } op_e;

  localparam int REG_W   = 16;
  localparam int START_B = 15;
  localparam int CODE_W  = 15;
  localparam int RGN_W   = 7;

  // erase region bit positions (decoded by the array model)
  localparam int RG_GEN  = 0;
  localparam int RG_GCFG = 1;
  localparam int RG_SEC  = 2;
  localparam int RG_SCFG = 3;
  localparam int RG_EXEC = 4;
  localparam int RG_PROT = 5;
  localparam int RG_ID   = 6;

  localparam logic [CODE_W-1:0] CODE_BULK = 15'h404F;
  localparam logic [CODE_W-1:0] CODE_GSEG = 15'h404D;
  localparam logic [CODE_W-1:0] CODE_SSEG = 15'h404C;
  localparam logic [CODE_W-1:0] CODE_PAGE = 15'h4042;
  localparam logic [CODE_W-1:0] CODE_ROW  = 15'h4001;
  localparam logic [CODE_W-1:0] CODE_WORD = 15'h4003;
  localparam logic [CODE_W-1:0] CODE_CFG  = 15'h4000;

endpackage

// File: rtl/fseq_decode.sv
module fseq_decode
  import fseq_pkg::*;
#(
  parameter int CNT_W        = 6,
  parameter int BULK_CYC     = 40,
  parameter int SEG_CYC      = 24,
  parameter int PAGE_CYC     = 16,
  parameter int ROW_CYC      = 10,
  parameter int WORD_CYC     = 4,
  parameter int CFG_CYC      = 3
) (
  input  logic [CODE_W-1:0] code,
  output op_e               op,
  output logic              valid,
  output logic [CNT_W-1:0]  load_val
);

  always_comb begin
    op       = OP_NONE;
    valid    = 1'b1;
    load_val = '0;
    unique case (code)
      CODE_BULK: begin op = OP_BULK; load_val = CNT_W'(BULK_CYC - 1); end
      CODE_GSEG: begin op = OP_GSEG; load_val = CNT_W'(SEG_CYC - 1);  end
      CODE_SSEG: begin op = OP_SSEG; load_val = CNT_W'(SEG_CYC - 1);  end
      CODE_PAGE: begin op = OP_PAGE; load_val = CNT_W'(PAGE_CYC - 1); end
      CODE_ROW:  begin op = OP_ROW;  load_val = CNT_W'(ROW_CYC - 1);  end
      CODE_WORD: begin op = OP_WORD; load_val = CNT_W'(WORD_CYC - 1); end
      CODE_CFG:  begin op = OP_CFG;  load_val = CNT_W'(CFG_CYC - 1);  end
      default:   valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             cnt_zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == '0);

  // R2: a non-zero count that is not reloaded always moves down by one
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fseq_array_drv.sv
module fseq_array_drv
  import fseq_pkg::*;
(
  input  op_e              op,
  input  logic             fire,
  output logic [RGN_W-1:0] erase_mask,
  output logic             page_erase,
  output logic             row_prog,
  output logic             word_prog,
  output logic             cfg_prog
);

  always_comb begin
    erase_mask = '0;
    page_erase = 1'b0;
    row_prog   = 1'b0;
    word_prog  = 1'b0;
    cfg_prog   = 1'b0;
    if (fire) begin
      unique case (op)
        OP_BULK: begin
          erase_mask[RG_GEN]  = 1'b1;
          erase_mask[RG_GCFG] = 1'b1;
          erase_mask[RG_SEC]  = 1'b1;
          erase_mask[RG_SCFG] = 1'b1;
          erase_mask[RG_EXEC] = 1'b1;
          erase_mask[RG_PROT] = 1'b1;
        end
        OP_SSEG: begin
          erase_mask[RG_SEC]  = 1'b1;
          erase_mask[RG_SCFG] = 1'b1;
          erase_mask[RG_GEN]  = 1'b1;
          erase_mask[RG_GCFG] = 1'b1;
        end
        OP_GSEG: begin
          erase_mask[RG_GEN]  = 1'b1;
          erase_mask[RG_GCFG] = 1'b1;
        end
        OP_PAGE: page_erase = 1'b1;
        OP_ROW:  row_prog   = 1'b1;
        OP_WORD: word_prog  = 1'b1;
        OP_CFG:  cfg_prog   = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fseq_pkg::*;
#(
  parameter int BULK_CYC = 40,
  parameter int SEG_CYC  = 24,
  parameter int PAGE_CYC = 16,
  parameter int ROW_CYC  = 10,
  parameter int WORD_CYC = 4,
  parameter int CFG_CYC  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        busy,
  output logic        err,
  output logic [6:0]  erase_mask,
  output logic        page_erase,
  output logic        row_prog,
  output logic        word_prog,
  output logic        cfg_prog
);

  localparam int MAX_E   = (BULK_CYC > SEG_CYC) ? BULK_CYC : SEG_CYC;
  localparam int MAX_EP  = (MAX_E > PAGE_CYC) ? MAX_E : PAGE_CYC;
  localparam int MAX_W   = (ROW_CYC > WORD_CYC) ? ROW_CYC : WORD_CYC;
  localparam int MAX_WC  = (MAX_W > CFG_CYC) ? MAX_W : CFG_CYC;
  localparam int MAX_CYC = (MAX_EP > MAX_WC) ? MAX_EP : MAX_WC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CODE_W-1:0] code_q, code_d;
  logic              wr_q, wr_d;
  logic              err_q, err_d;
  op_e               op_q, op_d;
  logic              code_en, wr_en, err_en, op_en;

  logic              accept, launch, fire, cnt_zero;
  op_e               dec_op;
  logic              dec_valid;
  logic [CNT_W-1:0]  dec_load;
  logic              any_strobe;

  fseq_decode #(
    .CNT_W(CNT_W), .BULK_CYC(BULK_CYC), .SEG_CYC(SEG_CYC), .PAGE_CYC(PAGE_CYC),
    .ROW_CYC(ROW_CYC), .WORD_CYC(WORD_CYC), .CFG_CYC(CFG_CYC)
  ) u_decode (
    .code     (reg_wdata[CODE_W-1:0]),
    .op       (dec_op),
    .valid    (dec_valid),
    .load_val (dec_load)
  );

  fseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch),
    .load_val (dec_load),
    .cnt_zero (cnt_zero)
  );

  // next-state logic
  always_comb begin
    accept  = reg_wr && !wr_q;
    launch  = accept && reg_wdata[START_B];
    fire    = wr_q && cnt_zero;

    code_en = accept;
    code_d  = reg_wdata[CODE_W-1:0];

    wr_en   = launch || fire;
    wr_d    = launch;

    op_en   = launch;
    op_d    = dec_valid ? dec_op : OP_NONE;

    err_en  = accept;
    err_d   = launch && !dec_valid;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
      op_q   <= OP_NONE;
    end else begin
      if (code_en) code_q <= code_d;
      if (wr_en)   wr_q   <= wr_d;
      if (err_en)  err_q  <= err_d;
      if (op_en)   op_q   <= op_d;
    end
  end

  fseq_array_drv u_array (
    .op         (op_q),
    .fire       (fire),
    .erase_mask (erase_mask),
    .page_erase (page_erase),
    .row_prog   (row_prog),
    .word_prog  (word_prog),
    .cfg_prog   (cfg_prog)
  );

  assign reg_rdata  = {wr_q, code_q};
  assign busy       = wr_q;
  assign err        = err_q;
  assign any_strobe = (|erase_mask) || page_erase || row_prog || word_prog || cfg_prog;

  // R1: an idle start write raises the flag and shows the command next cycle
  a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && reg_rdata[CODE_W-1:0] == $past(reg_wdata[CODE_W-1:0])));

  // R2: the flag drops right after the final (strobe) cycle
  a_r2_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |=> !busy);

  // R5: secure-segment erase always nests the general segment
  a_r5_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    erase_mask[RG_SEC] |-> (erase_mask[RG_GEN] && erase_mask[RG_GCFG]));

  // R8: strobes only while busy, one kind at a time
  a_r8_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> busy);
  a_r8_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|erase_mask, page_erase, row_prog, word_prog, cfg_prog}));

  // R9: an undecoded launch lasts one cycle and flags an error
  a_r9_bad_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !dec_valid) |=> (busy && err && !any_strobe));
  a_r9_bad_short: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(launch && !dec_valid)) |=> !busy);

  // R10: writes during an operation leave the command untouched
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> $stable(reg_rdata[CODE_W-1:0]));

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        busy, err;
  logic [6:0]  erase_mask;
  logic        page_erase, row_prog, word_prog, cfg_prog;

  int n_chk  = 0;
  int n_fail = 0;

  flash_cmd_seq u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .err(err), .erase_mask(erase_mask),
    .page_erase(page_erase), .row_prog(row_prog), .word_prog(word_prog),
    .cfg_prog(cfg_prog)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // expected values from the requirements
  function automatic int exp_len(input logic [14:0] c);
    case (c)
      15'h404F: return 40;
      15'h404D: return 24;
      15'h404C: return 24;
      15'h4042: return 16;
      15'h4001: return 10;
      15'h4003: return 4;
      15'h4000: return 3;
      default:  return 1;
    endcase
  endfunction

  function automatic int exp_mask(input logic [14:0] c);
    case (c)
      15'h404F: return 'h3F;
      15'h404D: return 'h03;
      15'h404C: return 'h0F;
      default:  return 0;
    endcase
  endfunction

  // {cfg, word, row, page}
  function automatic int exp_kind(input logic [14:0] c);
    case (c)
      15'h4042: return 1;
      15'h4001: return 2;
      15'h4003: return 4;
      15'h4000: return 8;
      default:  return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [14:0] c);
    case (c)
      15'h404F: return "R3";
      15'h404D: return "R4";
      15'h404C: return "R5";
      15'h4042: return "R6";
      15'h4001, 15'h4003, 15'h4000: return "R7";
      default:  return "R9";
    endcase
  endfunction

  task automatic write_reg(input logic [15:0] w);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  // launch a command and check the whole busy window
  task automatic run_cmd(input logic [14:0] c);
    int cyc = 0;
    int nstr = 0;
    int at = 0;
    int mask = 0;
    int kind = 0;
    int len = exp_len(c);
    bit valid = (exp_mask(c) != 0) || (exp_kind(c) != 0);
    write_reg({1'b1, c});
    chk(reg_rdata == {1'b1, c}, "R1", "readback after launch", reg_rdata, {1'b1, c});
    while (busy && cyc < 1000) begin
      cyc++;
      chk(reg_rdata[15] == busy, "R2", "busy equals start flag", busy, reg_rdata[15]);
      if ((|erase_mask) || page_erase || row_prog || word_prog || cfg_prog) begin
        nstr++;
        at   = cyc;
        mask = erase_mask;
        kind = {cfg_prog, word_prog, row_prog, page_erase};
      end
      @(negedge clk);
    end
    chk(cyc == len, valid ? "R2" : "R9", "busy length", cyc, len);
    chk(nstr == (valid ? 1 : 0), valid ? "R8" : "R9", "strobe cycles", nstr, valid ? 1 : 0);
    if (valid) begin
      chk(at == len, "R8", "strobe on last busy cycle", at, len);
      chk(mask == exp_mask(c), req_of(c), "erase mask", mask, exp_mask(c));
      chk(kind == exp_kind(c), req_of(c), "strobe kind", kind, exp_kind(c));
    end
    chk(err == !valid, "R9", "error flag", err, !valid);
    chk(reg_rdata == {1'b0, c}, "R2", "readback after completion", reg_rdata, {1'b0, c});
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(reg_rdata == 16'h0, "R1", "reset readback", reg_rdata, 0);
    chk(!busy && !err, "R2", "reset busy/err", {busy, err}, 0);
    chk(erase_mask == 0 && !page_erase && !row_prog && !word_prog && !cfg_prog,
        "R8", "reset strobes", erase_mask, 0);

    // every defined command
    run_cmd(15'h404F);
    run_cmd(15'h404D);
    run_cmd(15'h404C);
    run_cmd(15'h4042);
    run_cmd(15'h4001);
    run_cmd(15'h4003);
    run_cmd(15'h4000);

    // sweep of the low byte under the command prefix, plus outliers
    for (int lo = 0; lo < 256; lo++) run_cmd(15'h4000 | 15'(lo));
    run_cmd(15'h004F);
    run_cmd(15'h504F);
    run_cmd(15'h7FFF);
    run_cmd(15'h0001);

    // R9: error cleared by the next accepted write (without start)
    run_cmd(15'h1234);
    chk(err == 1'b1, "R9", "error set before clear", err, 1);
    write_reg(16'h4003);
    chk(err == 1'b0, "R9", "error cleared by write", err, 0);
    // R11: write without start stores but does not launch
    chk(!busy, "R11", "no launch on bit15=0", busy, 0);
    chk(reg_rdata == 16'h4003, "R11", "stored command", reg_rdata, 16'h4003);
    repeat (5) begin
      @(negedge clk);
      chk(!busy && !row_prog && !word_prog && !cfg_prog && !page_erase && erase_mask == 0,
          "R11", "no activity after plain write", busy, 0);
    end

    // R10: writes during a bulk erase are dropped
    begin
      int cyc = 1;
      int at = 0;
      int mask = 0;
      write_reg(16'hC04F);
      @(negedge clk); cyc++;
      reg_wr = 1'b1; reg_wdata = 16'hC001;
      @(negedge clk); cyc++;
      reg_wr = 1'b0;
      chk(reg_rdata == 16'hC04F, "R10", "command held during busy", reg_rdata, 16'hC04F);
      reg_wr = 1'b1; reg_wdata = 16'h0042;
      @(negedge clk); cyc++;
      reg_wr = 1'b0;
      chk(reg_rdata == 16'hC04F, "R10", "plain write held during busy", reg_rdata, 16'hC04F);
      while (busy && cyc < 1000) begin
        if (|erase_mask || row_prog) begin at = cyc; mask = erase_mask; end
        @(negedge clk); cyc++;
      end
      cyc--;
      chk(cyc == 40, "R10", "length kept under writes", cyc, 40);
      chk(at == 40 && mask == 'h3F, "R10", "original strobe kept", mask, 'h3F);
      chk(reg_rdata == 16'h404F, "R10", "command after completion", reg_rdata, 16'h404F);
    end

    // back-to-back launch right after completion
    run_cmd(15'h4003);
    run_cmd(15'h404C);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule